// File: doc/BRIEF.md
# Nibble Operand Stack with Cached Top Element

This block is the operand stack of a 4-bit stack machine. The top element sits in a dedicated accumulator register (TOS). The elements below it live in a 256 x 4-bit RAM that the block contains. An 8-bit stack pointer (SP) always addresses the RAM cell that holds the second element (TOS-1). Both TOS and TOS-1 are driven out continuously, so an external ALU can combine them. One command per clock (push, drop, ALU writeback, dup, swap, pointer load, or a nibble transfer to or from the return stack) updates TOS, the RAM and SP in a single cycle.

Software can place the stack anywhere in the shared RAM and limit its depth by loading SP. A pointer that steps past FFh wraps to 00h and sets a sticky overflow flag. A pointer that steps below 00h wraps to FFh and sets a sticky underflow flag. The flags are tracked by a four-state machine:
- States: CLEAN, OVER, UNDER, BOTH.
- Transitions: CLEAN to OVER on an upward wrap; CLEAN to UNDER on a downward wrap; OVER to BOTH on a downward wrap; UNDER to BOTH on an upward wrap.
- BOTH is held until reset.

Top module: `nib_opstack`

## Requirements
- R1: After reset, tos_o is 0, sp_o is 00h and both ovf_o and unf_o are 0.
- R2: Push (cmd_i = 1) writes the old TOS into RAM at SP+1, increments SP and loads TOS from push_data_i. From the next cycle, nos_o shows the old TOS.
- R3: Drop (cmd_i = 2) loads TOS from the RAM cell at SP and decrements SP.
- R4: ALU writeback (cmd_i = 3) loads TOS from alu_res_i and decrements SP, so TOS-1 is consumed, all in one cycle.
- R5: Dup (cmd_i = 4) writes TOS into RAM at SP+1 and increments SP. TOS is unchanged, so TOS and TOS-1 become equal.
- R6: Swap (cmd_i = 5) exchanges TOS with the RAM cell at SP and leaves SP unchanged.
- R7: Pointer load (cmd_i = 6) sets SP to sp_load_i and leaves TOS unchanged.
- R8: From-return-stack (cmd_i = 7) pushes rs_data_i like R2. To-return-stack (cmd_i = 8) drops like R3 and asserts rs_wr_o in that same cycle; while rs_wr_o is high, tos_o carries the nibble handed over.
- R9: An SP increment from FFh wraps SP to 00h and sets ovf_o. ovf_o then stays 1 until reset, even after a pointer load.
- R10: An SP decrement from 00h wraps SP to FFh and sets unf_o. unf_o then stays 1 until reset, even after a pointer load.
- R11: Codes 0 and 9 to 15 change neither TOS, SP, RAM nor the flags, and they hold rs_wr_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Command code for this cycle |
| push_data_i | input | 4 | Nibble pushed by command 1 |
| alu_res_i | input | 4 | ALU result written back by command 3 |
| rs_data_i | input | 4 | Nibble taken from the return stack by command 7 |
| sp_load_i | input | 8 | New pointer value for command 6 |
| tos_o | output | 4 | Top element (TOS) |
| nos_o | output | 4 | Second element (RAM cell at SP) |
| sp_o | output | 8 | Current stack pointer |
| rs_wr_o | output | 1 | Return stack should capture tos_o this cycle |
| ovf_o | output | 1 | Sticky pointer overflow |
| unf_o | output | 1 | Sticky pointer underflow |

## Verification
Several properties are checked on every cycle:
- the pointer steps by exactly one on a push, dup or from-return-stack, and holds when no step is requested;
- the ALU result lands in TOS;
- push and swap move the old values between TOS and TOS-1;
- idle codes leave TOS and SP untouched;
- the flags set on a wrap and never clear.

RAM contents several levels deep can only be shown by the bench's scenarios, which drop back through earlier pushes. The same applies to wrap behaviour at the FFh and 00h edges, flags that survive a pointer load, and long random command mixes compared against a reference model.

// File: rtl/opstk_pkg.sv
package opstk_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_PUSH   = 4'd1,
        OP_DROP   = 4'd2,
        OP_BINOP  = 4'd3,
        OP_DUP    = 4'd4,
        OP_SWAP   = 4'd5,
        OP_LDSP   = 4'd6,
        OP_FROMRS = 4'd7,
        OP_TORS   = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        FL_CLEAN = 2'd0,
        FL_OVER  = 2'd1,
        FL_UNDER = 2'd2,
        FL_BOTH  = 2'd3
    } flag_state_e;

endpackage

// File: rtl/opstk_ram.sv
module opstk_ram #(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read: TOS-1 is available in the same cycle as SP.
    assign rdata = mem[raddr];

endmodule

// File: rtl/opstk_ptr.sv
module opstk_ptr #(
    parameter int unsigned PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] sp_up_o,
    output logic             wrap_up_o,
    output logic             wrap_dn_o
);
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_d;

    assign sp_up_o   = sp_q + PTR_W'(1);
    assign wrap_up_o = inc && (sp_q == {PTR_W{1'b1}});
    assign wrap_dn_o = dec && (sp_q == {PTR_W{1'b0}});

    always_comb begin
        sp_d = sp_q;
        if (ld) begin
            sp_d = ld_val;
        end else if (inc) begin
            sp_d = sp_up_o;
        end else if (dec) begin
            sp_d = sp_q - PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

    assign sp_o = sp_q;

    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !((inc && dec) || (inc && ld) || (dec && ld)));

    p_inc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> sp_q == $past(sp_q) + PTR_W'(1));

    p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> sp_q == $past(sp_q) - PTR_W'(1));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec && !ld) |=> $stable(sp_q));

endmodule

// File: rtl/opstk_flags.sv
module opstk_flags
    import opstk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_up,
    input  logic wrap_dn,
    output logic ovf_o,
    output logic unf_o
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAN: begin
                if (wrap_up) begin
                    state_d = FL_OVER;
                end else if (wrap_dn) begin
                    state_d = FL_UNDER;
                end
            end
            FL_OVER: begin
                if (wrap_dn) begin
                    state_d = FL_BOTH;
                end
            end
            FL_UNDER: begin
                if (wrap_up) begin
                    state_d = FL_BOTH;
                end
            end
            FL_BOTH: begin
                state_d = FL_BOTH;
            end
        endcase
    end

    always_comb begin
        ovf_o = (state_q == FL_OVER)  || (state_q == FL_BOTH);
        unf_o = (state_q == FL_UNDER) || (state_q == FL_BOTH);
    end

    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_up |=> ovf_o);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    p_unf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_dn |=> unf_o);

    p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

endmodule

// File: rtl/nib_opstack.sv
module nib_opstack
    import opstk_pkg::*;
#(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic [DATA_W-1:0] alu_res_i,
    input  logic [DATA_W-1:0] rs_data_i,
    input  logic [PTR_W-1:0]  sp_load_i,
    output logic [DATA_W-1:0] tos_o,
    output logic [DATA_W-1:0] nos_o,
    output logic [PTR_W-1:0]  sp_o,
    output logic              rs_wr_o,
    output logic              ovf_o,
    output logic              unf_o
);
    op_e               op;
    logic [DATA_W-1:0] tos_q;
    logic [DATA_W-1:0] tos_d;
    logic [DATA_W-1:0] nos;
    logic [PTR_W-1:0]  sp;
    logic [PTR_W-1:0]  sp_up;
    logic              sp_inc;
    logic              sp_dec;
    logic              sp_ld;
    logic              ram_we;
    logic [PTR_W-1:0]  ram_waddr;
    logic              wrap_up;
    logic              wrap_dn;

    assign op = op_e'(cmd_i);

    opstk_ptr #(.PTR_W(PTR_W)) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (sp_inc),
        .dec       (sp_dec),
        .ld        (sp_ld),
        .ld_val    (sp_load_i),
        .sp_o      (sp),
        .sp_up_o   (sp_up),
        .wrap_up_o (wrap_up),
        .wrap_dn_o (wrap_dn)
    );

    opstk_ram #(.DATA_W(DATA_W), .ADDR_W(PTR_W)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (tos_q),
        .raddr (sp),
        .rdata (nos)
    );

    opstk_flags i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_up (wrap_up),
        .wrap_dn (wrap_dn),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o)
    );

    // Command decode: one process for all next-state control.
    always_comb begin
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        sp_ld     = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = sp_up;
        tos_d     = tos_q;
        rs_wr_o   = 1'b0;
        unique case (op)
            OP_PUSH: begin
                ram_we = 1'b1;
                sp_inc = 1'b1;
                tos_d  = push_data_i;
            end
            OP_FROMRS: begin
                ram_we = 1'b1;
                sp_inc = 1'b1;
                tos_d  = rs_data_i;
            end
            OP_DUP: begin
                ram_we = 1'b1;
                sp_inc = 1'b1;
            end
            OP_DROP: begin
                sp_dec = 1'b1;
                tos_d  = nos;
            end
            OP_TORS: begin
                sp_dec  = 1'b1;
                tos_d   = nos;
                rs_wr_o = 1'b1;
            end
            OP_BINOP: begin
                sp_dec = 1'b1;
                tos_d  = alu_res_i;
            end
            OP_SWAP: begin
                ram_we    = 1'b1;
                ram_waddr = sp;
                tos_d     = nos;
            end
            OP_LDSP: begin
                sp_ld = 1'b1;
            end
            default: begin
                // OP_NOP and unused codes: nothing changes.
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tos_q <= '0;
        end else begin
            tos_q <= tos_d;
        end
    end

    assign tos_o = tos_q;
    assign nos_o = nos;
    assign sp_o  = sp;

    p_push_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd1) |=> (tos_o == $past(push_data_i)) && (nos_o == $past(tos_o)));

    p_binop_tos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd3) |=> tos_o == $past(alu_res_i));

    p_swap_exch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd5) |=> (tos_o == $past(nos_o)) && (nos_o == $past(tos_o)));

    p_ldsp_tos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd6) |=> (sp_o == $past(sp_load_i)) && $stable(tos_o));

    p_idle_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == 4'd0) || (cmd_i > 4'd8)) |=> $stable(tos_o) && $stable(sp_o));

endmodule

// File: tb/test_nib_opstack.sv
module test_nib_opstack;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = 4'd0;
    logic [3:0] pd = 4'd0;
    logic [3:0] ar = 4'd0;
    logic [3:0] rd = 4'd0;
    logic [7:0] sl = 8'd0;
    logic [3:0] tos;
    logic [3:0] nos;
    logic [7:0] sp;
    logic       rs_wr;
    logic       ovf;
    logic       unf;

    int n_tests = 0;
    int n_fail  = 0;

    logic [3:0] m_ram [256];
    bit         m_known [256];
    logic [3:0] m_tos;
    bit         m_tos_known;
    logic [7:0] m_sp;
    bit         m_ovf;
    bit         m_unf;

    always #10 clk = ~clk;

    nib_opstack i_nib_opstack (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .push_data_i (pd),
        .alu_res_i   (ar),
        .rs_data_i   (rd),
        .sp_load_i   (sl),
        .tos_o       (tos),
        .nos_o       (nos),
        .sp_o        (sp),
        .rs_wr_o     (rs_wr),
        .ovf_o       (ovf),
        .unf_o       (unf)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic model(input logic [3:0] c);
        logic [7:0] up;
        logic [3:0] tmp;
        bit         tk;
        up = m_sp + 8'd1;
        case (c)
            4'd1, 4'd4, 4'd7: begin
                m_ram[up]   = m_tos;
                m_known[up] = m_tos_known;
                if (m_sp == 8'hFF) m_ovf = 1'b1;
                m_sp = up;
                if (c == 4'd1) begin m_tos = pd; m_tos_known = 1'b1; end
                if (c == 4'd7) begin m_tos = rd; m_tos_known = 1'b1; end
            end
            4'd2, 4'd8, 4'd3: begin
                if (c == 4'd3) begin
                    m_tos = ar; m_tos_known = 1'b1;
                end else begin
                    m_tos = m_ram[m_sp]; m_tos_known = m_known[m_sp];
                end
                if (m_sp == 8'h00) m_unf = 1'b1;
                m_sp = m_sp - 8'd1;
            end
            4'd5: begin
                tmp = m_ram[m_sp];
                tk  = m_known[m_sp];
                m_ram[m_sp]   = m_tos;
                m_known[m_sp] = m_tos_known;
                m_tos = tmp;
                m_tos_known = tk;
            end
            4'd6: m_sp = sl;
            default: ;
        endcase
    endtask

    task automatic step(input logic [3:0] c, input logic [3:0] d,
                        input logic [3:0] a, input logic [3:0] r,
                        input logic [7:0] s, input string flag_rq);
        string rq;
        rq = req_of(c);
        @(negedge clk);
        cmd = c; pd = d; ar = a; rd = r; sl = s;
        #1;
        chk({rq, " rs_wr"}, int'(rs_wr), (c == 4'd8) ? 1 : 0);
        if (c == 4'd8 && m_tos_known) chk("R8 handed nibble", int'(tos), int'(m_tos));
        @(posedge clk);
        #1;
        model(c);
        if (m_tos_known) chk({rq, " tos"}, int'(tos), int'(m_tos));
        chk({rq, " sp"}, int'(sp), int'(m_sp));
        if (m_known[m_sp]) chk({rq, " nos"}, int'(nos), int'(m_ram[m_sp]));
        chk({flag_rq, " ovf R9"}, int'(ovf), int'(m_ovf));
        chk({flag_rq, " unf R10"}, int'(unf), int'(m_unf));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] c;
        void'($urandom(32'd20417));
        for (int i = 0; i < 256; i++) begin m_known[i] = 1'b0; m_ram[i] = 4'd0; end
        m_tos = 4'd0; m_tos_known = 1'b1; m_sp = 8'd0; m_ovf = 1'b0; m_unf = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 tos", int'(tos), 0);
        chk("R1 sp", int'(sp), 0);
        chk("R1 ovf", int'(ovf), 0);
        chk("R1 unf", int'(unf), 0);
        rst_n = 1'b1;

        // Directed: build a stack away from the edges
        step(4'd6, 0, 0, 0, 8'h40, "R7");
        step(4'd1, 4'h3, 0, 0, 0, "R2");
        step(4'd1, 4'hA, 0, 0, 0, "R2");
        step(4'd1, 4'h5, 0, 0, 0, "R2");
        step(4'd4, 0, 0, 0, 0, "R5");
        step(4'd5, 0, 0, 0, 0, "R6");
        step(4'd3, 0, 4'hC, 0, 0, "R4");
        step(4'd5, 0, 0, 0, 0, "R6");
        step(4'd7, 0, 0, 4'h9, 0, "R8");
        step(4'd8, 0, 0, 0, 0, "R8");
        step(4'd2, 0, 0, 0, 0, "R3");
        step(4'd2, 0, 0, 0, 0, "R3");
        for (int k = 9; k < 16; k++) step(4'(k), 4'hF, 4'hF, 4'hF, 8'hFF, "R11");
        step(4'd0, 4'hF, 4'hF, 4'hF, 8'hFF, "R11");

        // Overflow at FFh
        step(4'd6, 0, 0, 0, 8'hFE, "R7");
        step(4'd1, 4'h1, 0, 0, 0, "R9");
        step(4'd1, 4'h2, 0, 0, 0, "R9");
        step(4'd6, 0, 0, 0, 8'h80, "R9");
        // Underflow at 00h
        step(4'd6, 0, 0, 0, 8'h01, "R7");
        step(4'd2, 0, 0, 0, 0, "R10");
        step(4'd3, 0, 4'h6, 0, 0, "R10");
        step(4'd6, 0, 0, 0, 8'h80, "R10");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            c = 4'($urandom % 16);
            if (c == 4'd6 && ($urandom % 8) != 0) c = 4'd1;
            if (c > 4'd8 && ($urandom % 4) != 0) c = 4'($urandom % 6);
            step(c, 4'($urandom), 4'($urandom), 4'($urandom), 8'($urandom), "R9 R10");
        end

        @(negedge clk);
        cmd = 4'd0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule